// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit works out where an 8-bit processor's instruction finds its operand. The instruction sequencer pulses `start` with the opcode, its operand bytes, the two index registers and the program counter. The unit decodes the addressing mode from the opcode bit fields and forms the 16-bit effective address. When the mode is indirect, it first fetches a two-byte pointer through a byte-wide read port. The same path also forms the target of a relative branch and of the indirect jump. For the indirect jump, a configuration input selects between two behaviours at a page boundary. In one, the jump keeps its pointer inside one page. In the other, the pointer carries into the next page.

A result is a one-cycle `ea_valid` pulse. It comes with the address and with a flag that marks an immediate operand. Modes that carry no address (accumulator, implied, unused encodings) return address zero with the flag low. Executing the instruction and updating flags belong to the neighbouring stages.

Top module: `operand_ea_unit`

## Requirements
- R1: While reset is applied, `ea_valid`, `mem_rd`, `ea_is_imm` and `ea` are all zero.
- R2: A mode that needs no pointer fetch raises `ea_valid` for exactly one cycle, after the second rising edge counting the edge that samples `start`.
- R3: The mode is taken from opcode bits [4:2] and the group from bits [1:0]. In group 1, modes 0..7 are: pre-indexed indirect, zero page, immediate, absolute, post-indexed indirect, zero page+X, absolute+Y, absolute+X. Operand bytes combine little-endian (`oper_lo` is address bits 7:0).
- R4: In groups 0 and 2, mode 1 is zero page, mode 3 is absolute, mode 5 is zero page indexed and mode 7 is absolute indexed. Indexing uses X, except that opcodes 0x96 and 0xB6 index the zero page with Y and opcode 0xBE indexes the absolute address with Y.
- R5: A zero-page indexed sum wraps within 8 bits, giving 0x00nn. An absolute indexed sum wraps within 16 bits.
- R6: Pre-indexed indirect reads the pointer low byte at (oper_lo+X) mod 256, then the high byte at that value plus one, mod 256. Both reads are in page zero. The result appears after the fourth rising edge counting the `start` edge.
- R7: Post-indexed indirect reads at oper_lo, then at (oper_lo+1) mod 256. It then adds Y to the fetched pointer, mod 65536.
- R8: Opcode 0x6C reads its target low byte at {oper_hi,oper_lo}. With `jmp_page_bug` high and oper_lo = 0xFF, it reads the high byte at {oper_hi,0x00}. Otherwise it reads the high byte at {oper_hi,oper_lo}+1.
- R9: A group-0 opcode whose bits [4:0] are 10000 is a relative branch. Its address is pc_in plus the sign-extended oper_lo, mod 65536.
- R10: Immediate mode raises `ea_is_imm` and returns address 0. In group 0 this is mode 0 with opcode bit 7 set. Modes with no address return 0 with `ea_is_imm` low. This covers group 0/2 modes 2, 4 (non-branch) and 6, group 0 mode 0 with bit 7 clear, and all of group 3.
- R11: `start` is ignored while a lookup is in progress. The result belongs to the instruction accepted first.
- R12: `mem_rd` is raised for exactly two consecutive cycles in an indirect lookup and never otherwise. `mem_rdata` is taken one cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a new instruction (honoured when idle) |
| opcode | input | 8 | Instruction opcode |
| oper_lo | input | 8 | First operand byte |
| oper_hi | input | 8 | Second operand byte |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| pc_in | input | 16 | Program counter after the instruction |
| jmp_page_bug | input | 1 | 1: indirect jump pointer stays inside its page |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| ea_valid | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address or branch/jump target |
| ea_is_imm | output | 1 | Operand is the immediate byte |

## Verification
Several properties are checked on every cycle:
- the result strobe lasts one cycle;
- an immediate result carries address zero;
- pointer reads come in back-to-back pairs;
- indirect zero-page reads stay in page zero;
- the second pointer read is one byte above the first within the page, or for the jump in page-keeping mode, on the same page;
- a captured instruction is held while a lookup runs.

Only the bench scenarios can show the actual address values. These are the mode decode across the groups, the X/Y exceptions, the 8-bit and 16-bit wraps, the pointer arithmetic with fetched bytes, branch sign extension, and whether a `start` during a lookup is dropped.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned OP_W = 8;

  typedef enum logic [3:0] {
    AM_NONE,
    AM_IMM,
    AM_ZP,
    AM_ABS,
    AM_ZP_IDX,
    AM_ABS_IDX,
    AM_IND_X,
    AM_IND_Y,
    AM_JMP_IND,
    AM_REL
  } am_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RDHI,
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
  import eag_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output am_kind_e        kind,
  output logic            use_y
);
  logic [1:0] grp;
  logic [2:0] mode;

  always_comb begin
    grp   = opcode[1:0];
    mode  = opcode[4:2];
    kind  = AM_NONE;
    use_y = 1'b0;
    if (opcode == 8'h6C) begin
      kind = AM_JMP_IND;
    end else if (grp == 2'd1) begin
      case (mode)
        3'd0: kind = AM_IND_X;
        3'd1: kind = AM_ZP;
        3'd2: kind = AM_IMM;
        3'd3: kind = AM_ABS;
        3'd4: kind = AM_IND_Y;
        3'd5: kind = AM_ZP_IDX;
        3'd6: begin kind = AM_ABS_IDX; use_y = 1'b1; end
        default: kind = AM_ABS_IDX;
      endcase
    end else if (grp != 2'd3) begin
      case (mode)
        3'd0: kind = (grp == 2'd2 || opcode[7]) ? AM_IMM : AM_NONE;
        3'd1: kind = AM_ZP;
        3'd3: kind = AM_ABS;
        3'd4: kind = (grp == 2'd0 && opcode[4:0] == 5'b10000) ? AM_REL : AM_NONE;
        3'd5: begin
          kind  = AM_ZP_IDX;
          use_y = (opcode == 8'h96) || (opcode == 8'hB6);
        end
        3'd7: begin
          kind  = AM_ABS_IDX;
          use_y = (opcode == 8'hBE);
        end
        default: kind = AM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  am_kind_e                kind,
  input  logic                    use_y,
  input  logic [DATA_W-1:0]       op_lo,
  input  logic [DATA_W-1:0]       op_hi,
  input  logic [DATA_W-1:0]       idx_x,
  input  logic [DATA_W-1:0]       idx_y,
  input  logic [2*DATA_W-1:0]     pc,
  input  logic                    page_bug,
  input  logic [DATA_W-1:0]       rd_lo,
  input  logic [DATA_W-1:0]       rd_hi,
  output logic [2*DATA_W-1:0]     direct_ea,
  output logic [2*DATA_W-1:0]     ptr_first,
  output logic [2*DATA_W-1:0]     ptr_second,
  output logic [2*DATA_W-1:0]     indirect_ea
);
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZERO_B = '0;

  logic [DATA_W-1:0] idx;
  logic [DATA_W-1:0] zp_sum;
  logic [DATA_W-1:0] zp_ptr;
  logic [DATA_W-1:0] zp_ptr_nx;
  logic [ADDR_W-1:0] abs_base;
  logic [ADDR_W-1:0] abs_next;
  logic [ADDR_W-1:0] rel_off;

  always_comb begin
    idx       = use_y ? idx_y : idx_x;
    abs_base  = {op_hi, op_lo};
    abs_next  = abs_base + 1'b1;
    zp_sum    = op_lo + idx;
    zp_ptr    = (kind == AM_IND_X) ? (op_lo + idx_x) : op_lo;
    zp_ptr_nx = zp_ptr + 1'b1;
    rel_off   = {{DATA_W{op_lo[DATA_W-1]}}, op_lo};

    case (kind)
      AM_ZP:      direct_ea = {ZERO_B, op_lo};
      AM_ABS:     direct_ea = abs_base;
      AM_ZP_IDX:  direct_ea = {ZERO_B, zp_sum};
      AM_ABS_IDX: direct_ea = abs_base + {ZERO_B, idx};
      AM_REL:     direct_ea = pc + rel_off;
      default:    direct_ea = '0;
    endcase

    if (kind == AM_JMP_IND) begin
      ptr_first  = abs_base;
      ptr_second = (page_bug && (&op_lo)) ? {op_hi, ZERO_B} : abs_next;
    end else begin
      ptr_first  = {ZERO_B, zp_ptr};
      ptr_second = {ZERO_B, zp_ptr_nx};
    end

    indirect_ea = {rd_hi, rd_lo} + ((kind == AM_IND_Y) ? {ZERO_B, idx_y} : {ADDR_W{1'b0}});
  end
endmodule

// File: rtl/operand_ea_unit.sv
module operand_ea_unit
  import eag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [OP_W-1:0]       opcode,
  input  logic [DATA_W-1:0]     oper_lo,
  input  logic [DATA_W-1:0]     oper_hi,
  input  logic [DATA_W-1:0]     reg_x,
  input  logic [DATA_W-1:0]     reg_y,
  input  logic [2*DATA_W-1:0]   pc_in,
  input  logic                  jmp_page_bug,
  output logic                  mem_rd,
  output logic [2*DATA_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ea_valid,
  output logic [2*DATA_W-1:0]   ea,
  output logic                  ea_is_imm
);
  localparam int unsigned ADDR_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  walk_st_e          st_q, st_d;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] lo_q, hi_q, x_q, y_q, ptrlo_q;
  logic [ADDR_W-1:0] pc_q, ea_q, ea_d;
  logic              bug_q, vld_q, vld_d, imm_q, imm_d;
  logic              take, is_ind, cap_lo;

  am_kind_e          kind;
  logic              use_y;
  logic [ADDR_W-1:0] direct_ea, ptr_first, ptr_second, indirect_ea;

  eag_mode_decode u_dec (
    .opcode (op_q),
    .kind   (kind),
    .use_y  (use_y)
  );

  eag_addr_calc #(.DATA_W(DATA_W)) u_calc (
    .kind        (kind),
    .use_y       (use_y),
    .op_lo       (lo_q),
    .op_hi       (hi_q),
    .idx_x       (x_q),
    .idx_y       (y_q),
    .pc          (pc_q),
    .page_bug    (bug_q),
    .rd_lo       (ptrlo_q),
    .rd_hi       (mem_rdata),
    .direct_ea   (direct_ea),
    .ptr_first   (ptr_first),
    .ptr_second  (ptr_second),
    .indirect_ea (indirect_ea)
  );

  // next-state and output logic
  always_comb begin
    is_ind = (kind == AM_IND_X) || (kind == AM_IND_Y) || (kind == AM_JMP_IND);
    take   = start && (st_q == ST_IDLE);
    cap_lo = (st_q == ST_RDHI);
    st_d   = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_EVAL;
      ST_EVAL: st_d = is_ind ? ST_RDHI : ST_IDLE;
      ST_RDHI: st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
    mem_rd   = ((st_q == ST_EVAL) && is_ind) || (st_q == ST_RDHI);
    mem_addr = !mem_rd ? '0 : ((st_q == ST_RDHI) ? ptr_second : ptr_first);
    vld_d    = ((st_q == ST_EVAL) && !is_ind) || (st_q == ST_FIN);
    ea_d     = (st_q == ST_FIN) ? indirect_ea : direct_ea;
    imm_d    = (st_q == ST_EVAL) && (kind == AM_IMM);
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      pc_q    <= '0;
      bug_q   <= 1'b0;
      ptrlo_q <= '0;
      vld_q   <= 1'b0;
      ea_q    <= '0;
      imm_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= vld_d;
      if (take) begin
        op_q  <= opcode;
        lo_q  <= oper_lo;
        hi_q  <= oper_hi;
        x_q   <= reg_x;
        y_q   <= reg_y;
        pc_q  <= pc_in;
        bug_q <= jmp_page_bug;
      end
      if (cap_lo) ptrlo_q <= mem_rdata;
      if (vld_d) begin
        ea_q  <= ea_d;
        imm_q <= imm_d;
      end
    end
  end

  assign ea_valid  = vld_q;
  assign ea        = ea_q;
  assign ea_is_imm = imm_q;

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ea_valid |=> !ea_valid);
  // R10
  imm_zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ea_valid && ea_is_imm) |-> (ea == '0));
  // R12
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_rd && st_q == ST_EVAL) |=> mem_rd);
  // R6
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_rd && (kind == AM_IND_X || kind == AM_IND_Y)) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));
  // R7
  zp_next_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RDHI && kind != AM_JMP_IND) |->
      (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1));
  // R8
  jind_page_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RDHI && kind == AM_JMP_IND && bug_q) |->
      (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])));
  // R11
  hold_op_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q != ST_IDLE) |=> $stable(op_q));
endmodule

// File: tb/operand_ea_unit_bench.sv
module operand_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, oper_lo, oper_hi, reg_x, reg_y;
  logic [15:0] pc_in;
  logic        jmp_page_bug;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        ea_valid;
  logic [15:0] ea;
  logic        ea_is_imm;

  int n_chk = 0;
  int n_fail = 0;
  int rd_n = 0;
  logic [15:0] rd_prev = '0, rd_cur = '0;

  always #2 clk = ~clk;

  operand_ea_unit u_operand_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .oper_lo(oper_lo), .oper_hi(oper_hi), .reg_x(reg_x), .reg_y(reg_y),
    .pc_in(pc_in), .jmp_page_bug(jmp_page_bug), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ea_valid(ea_valid),
    .ea(ea), .ea_is_imm(ea_is_imm)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  // byte-wide memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memf(mem_addr);
      rd_prev   <= rd_cur;
      rd_cur    <= mem_addr;
      rd_n      <= rd_n + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // one lookup against the reference model; interfere pulses start mid-lookup
  task automatic run_one(logic [7:0] op, logic [7:0] lo, logic [7:0] hi,
                         logic [7:0] x, logic [7:0] y, logic [15:0] pc,
                         logic bug, bit interfere, string req_over);
    logic [1:0]  grp;
    logic [2:0]  md;
    logic [7:0]  p, p1;
    logic [15:0] e_ea, r0, r1;
    bit          e_imm, e_ind;
    string       req;
    int          k, rd_start;
    grp = op[1:0]; md = op[4:2];
    e_ea = '0; e_imm = 0; e_ind = 0; r0 = '0; r1 = '0; req = "R10";
    if (op == 8'h6C) begin
      e_ind = 1; req = "R8";
      r0 = {hi, lo};
      r1 = (bug && lo == 8'hFF) ? {hi, 8'h00} : ({hi, lo} + 16'd1);
      e_ea = {memf(r1), memf(r0)};
    end else if (grp == 2'd1) begin
      case (md)
        3'd0: begin
          e_ind = 1; req = "R6";
          p = lo + x; p1 = p + 8'd1;
          r0 = {8'h00, p}; r1 = {8'h00, p1};
          e_ea = {memf(r1), memf(r0)};
        end
        3'd1: begin e_ea = {8'h00, lo}; req = "R3"; end
        3'd2: begin e_imm = 1; req = "R10"; end
        3'd3: begin e_ea = {hi, lo}; req = "R3"; end
        3'd4: begin
          e_ind = 1; req = "R7";
          p1 = lo + 8'd1;
          r0 = {8'h00, lo}; r1 = {8'h00, p1};
          e_ea = {memf(r1), memf(r0)} + {8'h00, y};
        end
        3'd5: begin p = lo + x; e_ea = {8'h00, p}; req = "R5"; end
        3'd6: begin e_ea = {hi, lo} + {8'h00, y}; req = "R5"; end
        default: begin e_ea = {hi, lo} + {8'h00, x}; req = "R5"; end
      endcase
    end else if (grp != 2'd3) begin
      case (md)
        3'd0: begin e_imm = (grp == 2'd2) || op[7]; req = "R10"; end
        3'd1: begin e_ea = {8'h00, lo}; req = "R4"; end
        3'd3: begin e_ea = {hi, lo}; req = "R4"; end
        3'd4: if (grp == 2'd0 && op[4:0] == 5'b10000) begin
          e_ea = pc + {{8{lo[7]}}, lo}; req = "R9";
        end
        3'd5: begin
          p = lo + ((op == 8'h96 || op == 8'hB6) ? y : x);
          e_ea = {8'h00, p}; req = "R4";
        end
        3'd7: begin e_ea = {hi, lo} + {8'h00, ((op == 8'hBE) ? y : x)}; req = "R4"; end
        default: req = "R10";
      endcase
    end
    if (req_over != "") req = req_over;

    @(negedge clk);
    opcode = op; oper_lo = lo; oper_hi = hi; reg_x = x; reg_y = y;
    pc_in = pc; jmp_page_bug = bug; start = 1'b1;
    rd_start = rd_n;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < 12) begin
      if (k == 0 && interfere) begin
        start = 1'b1; opcode = 8'hA9; oper_lo = 8'h11; oper_hi = 8'h22;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      k++;
      if (ea_valid) break;
    end
    check(e_ind ? "R6" : "R2", "latency", k, e_ind ? 3 : 1);
    check(req, "ea", int'(ea), int'(e_ea));
    check(req, "imm flag", int'(ea_is_imm), int'(e_imm));
    check("R12", "read count", rd_n - rd_start, e_ind ? 2 : 0);
    if (e_ind) begin
      check(req, "first pointer addr", int'(rd_prev), int'(r0));
      check(req, "second pointer addr", int'(rd_cur), int'(r1));
    end
    @(negedge clk);
    check("R2", "strobe width", int'(ea_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4321));
    start = 0; opcode = '0; oper_lo = '0; oper_hi = '0; reg_x = '0;
    reg_y = '0; pc_in = '0; jmp_page_bug = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "valid in reset", int'(ea_valid), 0);
    check("R1", "rd in reset", int'(mem_rd), 0);
    check("R1", "ea in reset", int'(ea), 0);
    check("R1", "imm in reset", int'(ea_is_imm), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // directed corner cases
    run_one(8'hAD, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, 0, 0, "R3");  // little-endian absolute
    run_one(8'hB5, 8'hF0, 8'h00, 8'h20, 8'h00, 16'h0000, 0, 0, "R5");  // zp,X wraps to 0x10
    run_one(8'hB6, 8'hF8, 8'h00, 8'h01, 8'h10, 16'h0000, 0, 0, "R4");  // zp,Y exception
    run_one(8'h96, 8'h05, 8'h00, 8'h01, 8'h03, 16'h0000, 0, 0, "R4");
    run_one(8'hBE, 8'h00, 8'h30, 8'h01, 8'h07, 16'h0000, 0, 0, "R4");  // abs,Y exception
    run_one(8'hBD, 8'hFF, 8'hFF, 8'h02, 8'h00, 16'h0000, 0, 0, "R5");  // 16-bit wrap
    run_one(8'hA1, 8'hFE, 8'h00, 8'h01, 8'h00, 16'h0000, 0, 0, "R6");  // pointer at 0xFF
    run_one(8'hB1, 8'hFF, 8'h00, 8'h00, 8'hC8, 16'h0000, 0, 0, "R7");  // hi byte from 0x00
    run_one(8'h6C, 8'hFF, 8'h40, 8'h00, 8'h00, 16'h0000, 1, 0, "R8");  // page kept
    run_one(8'h6C, 8'hFF, 8'h40, 8'h00, 8'h00, 16'h0000, 0, 0, "R8");  // carries
    run_one(8'h6C, 8'h10, 8'h40, 8'h00, 8'h00, 16'h0000, 1, 0, "R8");
    run_one(8'hD0, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h0001, 0, 0, "R9");  // backward across zero
    run_one(8'h10, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 0, 0, "R9");
    run_one(8'hA0, 8'h55, 8'h00, 8'h00, 8'h00, 16'h0000, 0, 0, "R10");
    run_one(8'h20, 8'h55, 8'h66, 8'h00, 8'h00, 16'h0000, 0, 0, "R10");
    run_one(8'h0A, 8'h55, 8'h66, 8'h00, 8'h00, 16'h0000, 0, 0, "R10");
    run_one(8'h69, 8'h55, 8'h66, 8'h00, 8'h00, 16'h0000, 0, 0, "R3");
    run_one(8'hB1, 8'h40, 8'h00, 8'h00, 8'h05, 16'h0000, 0, 1, "R11");
    run_one(8'hAD, 8'h40, 8'h99, 8'h00, 8'h05, 16'h0000, 0, 1, "R11");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] rop;
      rop = 8'($urandom);
      if (i % 8 == 0) rop = 8'h6C;
      run_one(rop, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              16'($urandom), 1'($urandom), (i % 17 == 0), "");
    end
    finish_run();
  end
endmodule